// File: doc/BRIEF.md
# PFC Power State and Startup Sequencer

This block decides when a power-factor-correction boost stage may switch. It takes six single-bit comparator results from the analog front end: supply above the turn-on level, supply below the turn-off level, feedback pin above its enable level, brown-out pin above its level, enable pin above its level, and output at 95% of rated value. Each flag passes through a two-flop synchronizer and a debounce filter before the state machine sees it. The block drives a gate-enable line, a soft-start-active line, an output-good line and a 2-bit state code.

The machine has four states. OFF holds everything low until supply, feedback and brown-out are all good together. The stage then waits in STANDBY for a settling window, measured in clock cycles, so that the internal reference can come up. It then ramps in SOFT_START until the output reaches 95%, and runs in NORMAL after that. If the feedback or enable pin drops, the stage parks in STANDBY. When that pin recovers, the ramp restarts in SOFT_START. If the supply falls under the turn-off level, the stage goes to OFF from any active state. Because turn-on and turn-off use two separate comparators, the supply has a hysteresis band.

Top module: `pfc_power_seq`

## Requirements
- R1: After reset the state code is OFF (00), and gate enable, soft-start-active and output-good are all low.
- R2: OFF is left only when turn-on supply, feedback and brown-out flags are all high at once (and turn-off supply is low). The exit always goes to STANDBY (01) first.
- R3: In SOFT_START or NORMAL, a low feedback flag or a low enable flag moves the block to STANDBY, and gate enable goes low.
- R4: SOFT_START (10) moves to NORMAL (11) when the 95% flag is high. Once in NORMAL, a later fall of the 95% flag has no effect.
- R5: Output-good is high only in NORMAL. Soft-start-active is high only in SOFT_START. Gate enable is high only in SOFT_START or NORMAL.
- R6: After OFF is left, gating starts exactly SETTLE_CYCLES+1 clock edges after the edge that entered STANDBY, provided feedback and enable are good.
- R7: A flag change that lasts fewer than DEBOUNCE_CYCLES clocks is ignored. A change that lasts DEBOUNCE_CYCLES clocks is accepted. An accepted change shows in the state SYNC_STAGES+DEBOUNCE_CYCLES+1 edges after the input changes.
- R8: STANDBY always exits to SOFT_START or OFF, never directly to NORMAL, even when the 95% flag is already high.
- R9: A high turn-off supply flag forces OFF from any active state and takes priority over standby. With the supply inside the hysteresis band (neither flag high), OFF is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_on_i | input | 1 | Supply above turn-on level (async) |
| supply_low_i | input | 1 | Supply below turn-off level (async) |
| fb_ok_i | input | 1 | Feedback pin above enable level (async) |
| brownout_ok_i | input | 1 | Brown-out pin above its level (async) |
| enable_ok_i | input | 1 | Enable pin above its level (async) |
| out_at95_i | input | 1 | Output at or above 95% of rated value (async) |
| gate_en_o | output | 1 | Gate driver may switch |
| soft_start_o | output | 1 | Soft-start ramp active |
| out_good_o | output | 1 | Output regulated (NORMAL) |
| state_o | output | 2 | State: 00 OFF, 01 STANDBY, 10 SOFT_START, 11 NORMAL |

## Verification
The bench sweeps every combination of the three startup flags. A design that treats the startup condition as an OR, or drops one term, would leave OFF on an incomplete set. It times the settle window and the filter latency to the exact edge, so an off-by-one in the counter shows up as gating one cycle early or late. It sends glitches one cycle shorter than the debounce count and exactly equal to it. It also returns from STANDBY with the 95% flag already high, which catches a design that skips SOFT_START. It asserts a supply drop together with a feedback drop, which catches a design that gives STANDBY priority over OFF, and it parks the supply in the hysteresis band, which catches a design that restarts too early.

// File: rtl/pfc_seq_pkg.sv
package pfc_seq_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_STBY = 2'd1,
    ST_SOFT = 2'd2,
    ST_NORM = 2'd3
  } pwr_state_e;

  localparam int NUM_FLAGS = 6;
  localparam int F_SUP_ON  = 0;
  localparam int F_SUP_LOW = 1;
  localparam int F_FB      = 2;
  localparam int F_BO      = 3;
  localparam int F_EN      = 4;
  localparam int F_AT95    = 5;

  typedef struct packed {
    logic at95;
    logic en;
    logic bo;
    logic fb;
    logic sup_low;
    logic sup_on;
  } flags_t;

endpackage

// File: rtl/pfc_flag_sync.sv
module pfc_flag_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pfc_flag_debounce.sv
module pfc_flag_debounce #(
  parameter int COUNT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_i,
  output logic deb_o
);
  localparam int CW = (COUNT < 2) ? 1 : $clog2(COUNT);
  localparam logic [CW-1:0] LAST = CW'(COUNT - 1);

  logic [CW-1:0] cnt_q;
  logic          deb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      deb_q <= 1'b0;
    end else if (sync_i == deb_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      deb_q <= sync_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign deb_o = deb_q;

  // R7
  deb_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(deb_q) |-> ($past(sync_i) == deb_q));
endmodule

// File: rtl/pfc_settle_timer.sv
module pfc_settle_timer #(
  parameter int CYCLES = 20000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic done_o
);
  localparam int TW = $clog2(CYCLES + 1);
  localparam logic [TW-1:0] LIMIT = TW'(CYCLES);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i)      cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIMIT);

  // R6
  settle_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && run_i) |=> done_o);
endmodule

// File: rtl/pfc_seq_fsm.sv
module pfc_seq_fsm
  import pfc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  flags_t     flg_i,
  input  logic       settle_done_i,
  output pwr_state_e state_o,
  output logic       gate_en_o,
  output logic       soft_start_o,
  output logic       out_good_o
);
  pwr_state_e state_q, nxt;
  logic       gate_q, ss_q, good_q;
  logic       start_ok, run_ok;

  assign start_ok = flg_i.sup_on && flg_i.fb && flg_i.bo && !flg_i.sup_low;
  assign run_ok   = flg_i.fb && flg_i.en;

  always_comb begin
    nxt = state_q;
    unique case (state_q)
      ST_OFF:  if (start_ok) nxt = ST_STBY;
      ST_STBY: begin
        if (flg_i.sup_low)               nxt = ST_OFF;
        else if (settle_done_i && run_ok) nxt = ST_SOFT;
      end
      ST_SOFT: begin
        if (flg_i.sup_low)  nxt = ST_OFF;
        else if (!run_ok)   nxt = ST_STBY;
        else if (flg_i.at95) nxt = ST_NORM;
      end
      ST_NORM: begin
        if (flg_i.sup_low)  nxt = ST_OFF;
        else if (!run_ok)   nxt = ST_STBY;
      end
      default: nxt = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OFF;
      gate_q  <= 1'b0;
      ss_q    <= 1'b0;
      good_q  <= 1'b0;
    end else begin
      state_q <= nxt;
      gate_q  <= (nxt == ST_SOFT) || (nxt == ST_NORM);
      ss_q    <= (nxt == ST_SOFT);
      good_q  <= (nxt == ST_NORM);
    end
  end

  assign state_o      = state_q;
  assign gate_en_o    = gate_q;
  assign soft_start_o = ss_q;
  assign out_good_o   = good_q;

  // R5
  good_gate_chk: assert property (@(posedge clk) disable iff (rst)
    out_good_o |-> gate_en_o);
  // R1
  off_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OFF) |-> (!gate_en_o && !out_good_o && !soft_start_o));
  // R9
  supply_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (flg_i.sup_low && state_q != ST_OFF) |=> (state_q == ST_OFF));
  // R8
  stby_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STBY) |=> (state_q != ST_NORM));
  // R6
  settle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STBY && !settle_done_i) |=> !gate_en_o);
  // R4
  normal_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_NORM && !flg_i.at95) |=> (state_q != ST_NORM));
  // R2
  off_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OFF && !start_ok) |=> (state_q == ST_OFF));
endmodule

// File: rtl/pfc_power_seq.sv
module pfc_power_seq
  import pfc_seq_pkg::*;
#(
  parameter int SYNC_STAGES     = 2,
  parameter int DEBOUNCE_CYCLES = 16,
  parameter int SETTLE_CYCLES   = 20000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       supply_on_i,
  input  logic       supply_low_i,
  input  logic       fb_ok_i,
  input  logic       brownout_ok_i,
  input  logic       enable_ok_i,
  input  logic       out_at95_i,
  output logic       gate_en_o,
  output logic       soft_start_o,
  output logic       out_good_o,
  output logic [1:0] state_o
);
  logic [NUM_FLAGS-1:0] raw, synced, clean;
  flags_t     flg;
  pwr_state_e st;
  logic       settle_done;

  assign raw[F_SUP_ON]  = supply_on_i;
  assign raw[F_SUP_LOW] = supply_low_i;
  assign raw[F_FB]      = fb_ok_i;
  assign raw[F_BO]      = brownout_ok_i;
  assign raw[F_EN]      = enable_ok_i;
  assign raw[F_AT95]    = out_at95_i;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    pfc_flag_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d_i(raw[i]), .q_o(synced[i]));
    pfc_flag_debounce #(.COUNT(DEBOUNCE_CYCLES)) u_deb (
      .clk(clk), .rst(rst), .sync_i(synced[i]), .deb_o(clean[i]));
  end

  assign flg = flags_t'(clean);

  pfc_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst(rst), .run_i(st != ST_OFF), .done_o(settle_done));

  pfc_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .flg_i(flg), .settle_done_i(settle_done),
    .state_o(st), .gate_en_o(gate_en_o), .soft_start_o(soft_start_o),
    .out_good_o(out_good_o));

  assign state_o = st;
endmodule

// File: tb/pfc_power_seq_test.sv
module pfc_power_seq_test;
  localparam int SYN = 2;
  localparam int DEB = 3;
  localparam int SET = 8;
  localparam int LAT = SYN + DEB + 1;

  localparam logic [1:0] S_OFF = 2'd0, S_STBY = 2'd1, S_SOFT = 2'd2, S_NORM = 2'd3;

  logic clk = 1'b0, rst = 1'b1;
  logic sup_on = 0, sup_low = 0, fb = 0, bo = 0, en = 0, at95 = 0;
  logic gate, ss, good;
  logic [1:0] st;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  pfc_power_seq #(.SYNC_STAGES(SYN), .DEBOUNCE_CYCLES(DEB), .SETTLE_CYCLES(SET)) uut (
    .clk(clk), .rst(rst), .supply_on_i(sup_on), .supply_low_i(sup_low),
    .fb_ok_i(fb), .brownout_ok_i(bo), .enable_ok_i(en), .out_at95_i(at95),
    .gate_en_o(gate), .soft_start_o(ss), .out_good_o(good), .state_o(st));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_st(input string tag, input logic [1:0] exp);
    logic [4:0] a, e;
    a = {st, gate, ss, good};
    e = {exp, exp[1], exp == S_SOFT, exp == S_NORM};
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s: {state,gate,ss,good} actual=%b expected=%b", tag, a, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    rst = 0;
    step(1);
    expect_st("R1 reset", S_OFF);

    // R2 sweep of startup flag combinations, enable held good
    en = 1;
    for (int c = 0; c < 7; c++) begin
      {sup_on, fb, bo} = 3'(c);
      step(LAT + 2);
      expect_st($sformatf("R2 combo %0d", c), S_OFF);
    end
    {sup_on, fb, bo} = 3'b000;
    step(LAT + 2);
    {sup_on, fb, bo} = 3'b111;
    step(LAT - 1);
    expect_st("R7 latency before", S_OFF);
    step(1);
    expect_st("R2 enter standby", S_STBY);
    step(SET);
    expect_st("R6 still settling", S_STBY);
    step(1);
    expect_st("R6 gating starts", S_SOFT);
    step(20);
    expect_st("R5 no good during ramp", S_SOFT);

    at95 = 1;
    step(LAT - 1);
    expect_st("R4 before 95", S_SOFT);
    step(1);
    expect_st("R4 normal", S_NORM);
    at95 = 0;
    step(LAT + 2);
    expect_st("R4 fall ignored", S_NORM);

    // R7 short glitch rejected, exact-length glitch accepted
    en = 0; step(DEB - 1); en = 1;
    step(LAT + 4);
    expect_st("R7 short glitch", S_NORM);
    en = 0; step(DEB); en = 1;
    step(LAT + 6);
    expect_st("R7 full glitch R8 ramp again", S_SOFT);
    at95 = 1;
    step(LAT + 1);
    expect_st("R4 normal again", S_NORM);

    // R3 enable path, R8 return through soft start with 95% high
    en = 0;
    step(LAT - 1);
    expect_st("R3 en before", S_NORM);
    step(1);
    expect_st("R3 en standby", S_STBY);
    en = 1;
    step(LAT);
    expect_st("R8 via soft start", S_SOFT);
    step(1);
    expect_st("R8 then normal", S_NORM);

    // R3 feedback path
    fb = 0;
    step(LAT);
    expect_st("R3 fb standby", S_STBY);
    fb = 1;
    step(LAT);
    expect_st("R8 fb soft start", S_SOFT);
    step(1);
    expect_st("R4 fb normal", S_NORM);

    // R9 supply drop from NORMAL, then hysteresis band
    sup_low = 1; sup_on = 0;
    step(LAT - 1);
    expect_st("R9 before drop", S_NORM);
    step(1);
    expect_st("R9 drop to off", S_OFF);
    sup_low = 0;
    step(LAT + 10);
    expect_st("R9 band holds off", S_OFF);
    sup_on = 1;
    step(LAT);
    expect_st("R2 restart standby", S_STBY);
    step(SET);
    expect_st("R6 resettle", S_STBY);
    step(1);
    expect_st("R6 regate", S_SOFT);
    step(1);
    expect_st("R4 renormal", S_NORM);

    // R9 priority over standby
    sup_low = 1; sup_on = 0; fb = 0;
    step(LAT);
    expect_st("R9 priority", S_OFF);

    // R9 drop while in STANDBY
    sup_low = 0; fb = 1;
    step(LAT + 2);
    sup_on = 1;
    step(LAT);
    expect_st("R2 standby again", S_STBY);
    sup_low = 1; sup_on = 0;
    step(LAT);
    expect_st("R9 standby to off", S_OFF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule